// File: doc/BRIEF.md
# Eight-bit ALU flag generator

This block is the combinational arithmetic and logic stage of an 8-bit accumulator datapath. It takes a first operand (normally the accumulator), a second operand, a carry-in and a 3-bit operation select. In the same cycle it returns an 8-bit result and a complete 8-bit flag byte. There are eight operations: add, add with carry, subtract, subtract with carry, compare, AND, XOR and OR. No register or clock sits inside the block. The caller decides when to capture the result and the flags.

The flag byte holds the usual status bits. It also holds two copy bits that mirror result bits 5 and 3. The half-carry bit is not taken from a nibble adder. It is read from one of two 8-entry tables, one for addition and one for subtraction. The table index is built from bit 3 of both operands and bit 3 of the raw result. Overflow comes from the sign bits of the operands and of the result.

Top module: `alu8_flag_unit`

## Requirements
- R1: With `op_i` = 0 (ADD) the result is (a+b) mod 256. With `op_i` = 1 (ADC) it is (a+b+cin) mod 256. Flag bit 0 (carry) is bit 8 of the full sum.
- R2: With `op_i` = 2 (SUB) the result is (a-b) mod 256. With `op_i` = 3 (SBC) it is (a-b-cin) mod 256. Flag bit 0 is set when the subtraction borrows, that is when the exact difference is negative.
- R3: With `op_i` = 4 (CMP) the result output equals the first operand. The flags are those of a plain subtraction a-b, and sign, zero, X and Y are taken from that difference.
- R4: With `op_i` = 5 (AND), 6 (XOR) or 7 (OR) the result is the bitwise function of the operands. Flag bit 0 is 0. Flag bit 4 (half-carry) is 1 for AND and 0 for XOR and OR.
- R5: Flag bit 7 (sign) equals bit 7 of the arithmetic result. Flag bit 6 (zero) is 1 exactly when that 8-bit result is zero.
- R6: Flag bit 5 copies bit 5 of the arithmetic result. Flag bit 3 copies bit 3 of that result.
- R7: For ADD and ADC, flag bit 4 is entry k of the table 0,0,1,0,1,0,1,1 (entries 0 to 7). Here k = 4·a[3] + 2·b[3] + r[3], and r is the raw sum. This equals the carry out of bit 3.
- R8: For SUB, SBC and CMP, flag bit 4 is entry k of the table 0,1,1,1,0,0,0,1, with k built the same way from the raw difference. This equals the borrow out of bit 3.
- R9: For ADD and ADC, flag bit 2 is 1 when a[7] equals b[7] and r[7] differs from a[7].
- R10: For SUB, SBC and CMP, flag bit 2 is 1 when a[7] differs from b[7] and r[7] differs from a[7].
- R11: For AND, XOR and OR, flag bit 2 is 1 when the result has an even number of one bits.
- R12: Flag bit 1 (subtract) is 1 for SUB, SBC and CMP, and 0 for the other five operations.
- R13: The carry-in has no effect on the result or the flags for ADD, SUB, CMP, AND, XOR and OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation select, encoded as in R1 to R4 |
| a_i | input | 8 | First operand (accumulator) |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry-in, used only by ADC and SBC |
| res_o | output | 8 | Operation result |
| flags_o | output | 8 | Flag byte: S, Z, Y, H, X, P/V, N, C from bit 7 down to bit 0 |

## Verification
Every operation is applied with every pair of operands, once with the carry-in low and once with it high. The bench compares each output field against a reference computed with integer arithmetic.

The ADD and SUB sweeps distinguish table-driven half-carry from a real nibble carry or borrow. They do this in all eight index cases, and with the carry-in folded in for ADC and SBC. The signed boundary pairs around 0x7F and 0x80 separate the add and subtract overflow rules. The runs with the carry-in high on the operations that ignore it are checked on their own, so a leak of the carry-in is reported under R13. For the logical operations, every result value exercises the parity bit.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg
// Holds what the ALU modules share: the operation encoding, the flag
// bit positions and the two half-carry tables.
// Assumes an 8-bit datapath with nibble boundary at bit 3.
package alu8_pkg;

    localparam int DATA_W   = 8;
    localparam int NIB_MSB  = 3;
    localparam int HC_IDX_W = 3;
    localparam int HC_ENT   = 1 << HC_IDX_W;

    // Positions of the bits in the flag byte
    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_Y  = 5;
    localparam int FLG_H  = 4;
    localparam int FLG_X  = 3;
    localparam int FLG_PV = 2;
    localparam int FLG_N  = 1;
    localparam int FLG_C  = 0;

    // Half-carry tables: bit k of the vector is table entry k
    localparam logic [HC_ENT-1:0] HC_ADD_TBL = 8'hD4; // 0,0,1,0,1,0,1,1
    localparam logic [HC_ENT-1:0] HC_SUB_TBL = 8'h8E; // 0,1,1,1,0,0,0,1

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_CMP = 3'd4,
        OP_AND = 3'd5,
        OP_XOR = 3'd6,
        OP_OR  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic y;
        logic h;
        logic x;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    // True for the operations that subtract (CMP included)
    function automatic logic op_is_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    endfunction

    // True for the operations that consume the carry-in
    function automatic logic op_uses_cin(alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBC);
    endfunction

    // True for the bitwise operations
    function automatic logic op_is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
// Module alu8_addsub
// A binary adder that also subtracts, by inverting the second operand
// and the carry-in. The carry output is returned as a borrow when
// sub_i is high.
// Assumes the caller has already gated the carry-in by operation.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] raw_o,
    output logic         carry_o
);
    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   total;

    // Choose the addend and the carry form for add or subtract
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_eff = sub_i ? ~cin_i : cin_i;
    end

    // One wide add; the top bit is the carry, or the inverted borrow
    always_comb begin
        total   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        raw_o   = total[W-1:0];
        carry_o = sub_i ? ~total[W] : total[W];
    end
endmodule

// File: rtl/alu8_hc_lut.sv
// Module alu8_hc_lut
// Reads a half-carry flag from a small constant table. The index
// carries the nibble-MSB bits of the two operands and of the result.
// Assumes TABLE bit k holds entry k.
module alu8_hc_lut #(
    parameter int                    IDX_W = 3,
    parameter logic [(1<<IDX_W)-1:0] TABLE = '0
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             hc_o
);
    // Table read
    always_comb hc_o = TABLE[idx_i];
endmodule

// File: rtl/alu8_logic.sv
// Module alu8_logic
// The bitwise unit: AND, XOR and OR of the two operands. Any other
// select gives zero, and the top module never uses that value.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    // Select the bitwise function
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_OR:   res_o = a_i | b_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flag_unit.sv
// Module alu8_flag_unit (top)
// The combinational 8-bit ALU with the full flag byte. Arithmetic
// passes through alu8_addsub, the bitwise operations through
// alu8_logic. The half-carry bit comes from one of two table
// instances, picked by add or subtract.
// Assumes the caller registers res_o and flags_o where it needs to.
module alu8_flag_unit
    import alu8_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    input  logic       cin_i,
    output logic [7:0] res_o,
    output logic [7:0] flags_o
);
    localparam int W   = DATA_W;
    localparam int MSB = W - 1;

    alu_op_e               op;
    logic                  is_sub;
    logic                  is_logic;
    logic                  cin_used;
    logic [W-1:0]          arith_raw;
    logic                  arith_carry;
    logic [W-1:0]          logic_res;
    logic [W-1:0]          flag_src;
    logic [HC_IDX_W-1:0]   hc_idx;
    logic                  hc_add;
    logic                  hc_sub;
    logic                  ovf;
    flags_t                flg;

    // Decode the operation select into its classes
    always_comb begin
        op       = alu_op_e'(op_i);
        is_sub   = op_is_sub(op);
        is_logic = op_is_logic(op);
        cin_used = op_uses_cin(op) & cin_i;
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a_i     (a_i),
        .b_i     (b_i),
        .cin_i   (cin_used),
        .sub_i   (is_sub),
        .raw_o   (arith_raw),
        .carry_o (arith_carry)
    );

    alu8_logic #(.W(W)) u_logic (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (logic_res)
    );

    // Build the lookup index from the nibble-MSB bits
    always_comb hc_idx = {a_i[NIB_MSB], b_i[NIB_MSB], arith_raw[NIB_MSB]};

    alu8_hc_lut #(.IDX_W(HC_IDX_W), .TABLE(HC_ADD_TBL)) u_hc_add (
        .idx_i (hc_idx),
        .hc_o  (hc_add)
    );

    alu8_hc_lut #(.IDX_W(HC_IDX_W), .TABLE(HC_SUB_TBL)) u_hc_sub (
        .idx_i (hc_idx),
        .hc_o  (hc_sub)
    );

    // Signed overflow from the three sign bits
    always_comb begin
        if (is_sub)
            ovf = (a_i[MSB] != b_i[MSB]) && (arith_raw[MSB] != a_i[MSB]);
        else
            ovf = (a_i[MSB] == b_i[MSB]) && (arith_raw[MSB] != a_i[MSB]);
    end

    // Pick the value that sign, zero and the copy bits describe
    always_comb flag_src = is_logic ? logic_res : arith_raw;

    // Assemble the flag byte
    always_comb begin
        flg.s  = flag_src[MSB];
        flg.z  = (flag_src == '0);
        flg.y  = flag_src[5];
        flg.x  = flag_src[3];
        flg.n  = is_sub;
        if (is_logic) begin
            flg.h  = (op == OP_AND);
            flg.pv = ~^logic_res;
            flg.c  = 1'b0;
        end else begin
            flg.h  = is_sub ? hc_sub : hc_add;
            flg.pv = ovf;
            flg.c  = arith_carry;
        end
    end

    // Drive the outputs; CMP hands the first operand back unchanged
    always_comb begin
        flags_o = flg;
        if (is_logic)
            res_o = logic_res;
        else if (op == OP_CMP)
            res_o = a_i;
        else
            res_o = arith_raw;
    end
endmodule

// File: rtl/alu8_flag_chk.sv
// Module alu8_flag_chk
// Checks the relations between the ports of alu8_flag_unit. It is
// attached to the top module by the bind statement at the end of this
// file. Every check is immediate because the block has no clock.
module alu8_flag_chk
    import alu8_pkg::*;
(
    input logic [2:0] op_i,
    input logic [7:0] a_i,
    input logic [7:0] b_i,
    input logic       cin_i,
    input logic [7:0] res_o,
    input logic [7:0] flags_o
);
    logic sub_cls;
    logic log_cls;

    // Classify the operation from the port value
    always_comb begin
        sub_cls = (op_i == 3'd2) || (op_i == 3'd3) || (op_i == 3'd4);
        log_cls = (op_i >= 3'd5);
    end

    // Check the port relations that each requirement fixes
    always_comb begin
        assert_sub_flag_R12: assert (flags_o[FLG_N] == sub_cls)
            else $error("subtract flag does not match the operation class");
        if (op_i == 3'd4) begin
            assert_cmp_keeps_a_R3: assert (res_o == a_i)
                else $error("compare changed the result");
        end
        if (log_cls) begin
            assert_logic_no_carry_R4: assert (flags_o[FLG_C] == 1'b0)
                else $error("logical operation set carry");
            assert_logic_parity_R11: assert (flags_o[FLG_PV] == ~^res_o)
                else $error("parity bit is wrong");
        end
        if (op_i != 3'd4) begin
            assert_zero_sign_R5: assert ((flags_o[FLG_Z] == (res_o == 8'h00)) &&
                                         (flags_o[FLG_S] == res_o[7]))
                else $error("sign or zero does not match the result");
            assert_copy_bits_R6: assert ((flags_o[FLG_Y] == res_o[5]) &&
                                         (flags_o[FLG_X] == res_o[3]))
                else $error("copy bits do not match the result");
        end
        if (op_i == 3'd0) begin
            assert_add_no_cin_R13: assert ({flags_o[FLG_C], res_o} ==
                                           ({1'b0, a_i} + {1'b0, b_i}))
                else $error("add result or carry is wrong");
        end
    end

    logic unused_cin;
    always_comb unused_cin = cin_i;
endmodule

bind alu8_flag_unit alu8_flag_chk u_flag_chk (
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .res_o   (res_o),
    .flags_o (flags_o)
);

// File: tb/alu8_flag_unit_tb.sv
`timescale 1ns/10ps
module alu8_flag_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       cin;
    logic [7:0] res;
    logic [7:0] flags;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    int  cycles = 0;

    always #2.5 clk = ~clk;

    alu8_flag_unit u_dut (
        .op_i    (op),
        .a_i     (a),
        .b_i     (b),
        .cin_i   (cin),
        .res_o   (res),
        .flags_o (flags)
    );

    // Reports one compared field
    task automatic cmp(input string req, input string what, input int act, input int exp);
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s op=%0d a=%02h b=%02h cin=%0d act=%0h exp=%0h",
                     req, what, op, a, b, cin, act, exp);
        end
    endtask

    // Builds the expected result and flags by integer arithmetic and compares them
    task automatic check_vec;
        int    ai = a, bi = b, ci, full, r, out, hn, cy, hc, pv, nf;
        string rr, rh, rp, rc;
        bit    ign;
        ign = (cin == 1'b1) && (op != 3'd1) && (op != 3'd3); // R13: carry-in ignored
        ci  = ((op == 3'd1) || (op == 3'd3)) ? int'(cin) : 0;
        nf  = 0;
        if (op <= 3'd1) begin // R1 add, R7 half carry, R9 overflow
            full = ai + bi + ci; r = full & 255; out = r; cy = full >> 8;
            hc = (((ai & 15) + (bi & 15) + ci) > 15) ? 1 : 0;
            pv = (((ai >> 7) == (bi >> 7)) && ((r >> 7) != (ai >> 7))) ? 1 : 0;
            rr = "R1"; rh = "R7"; rp = "R9"; rc = "R1";
        end else if (op <= 3'd4) begin // R2/R3 subtract, R8 half borrow, R10 overflow
            full = ai - bi - ci; r = full & 255; cy = (full < 0) ? 1 : 0;
            out = (op == 3'd4) ? ai : r;
            hn = (ai & 15) - (bi & 15) - ci; hc = (hn < 0) ? 1 : 0;
            pv = (((ai >> 7) != (bi >> 7)) && ((r >> 7) != (ai >> 7))) ? 1 : 0;
            nf = 1;
            rr = (op == 3'd4) ? "R3" : "R2"; rh = "R8"; rp = "R10"; rc = rr;
        end else begin // R4 bitwise, R11 parity
            r = (op == 3'd5) ? (ai & bi) : (op == 3'd6) ? (ai ^ bi) : (ai | bi);
            out = r; cy = 0; hc = (op == 3'd5) ? 1 : 0;
            pv = ($countones(r[7:0]) % 2 == 0) ? 1 : 0;
            rr = "R4"; rh = "R4"; rp = "R11"; rc = "R4";
        end
        n_vec++;
        if (ign) begin
            cmp("R13", "result", res, out);
            cmp("R13", "flags", flags,
                {r[7], (r == 0), r[5], hc[0], r[3], pv[0], nf[0], cy[0]});
        end else begin
            cmp(rr, "result", res, out);
            cmp("R5", "sign", flags[7], r >> 7);
            cmp("R5", "zero", flags[6], (r == 0) ? 1 : 0);
            cmp("R6", "Y", flags[5], (r >> 5) & 1);
            cmp(rh, "half", flags[4], hc);
            cmp("R6", "X", flags[3], (r >> 3) & 1);
            cmp(rp, "p/v", flags[2], pv);
            cmp("R12", "N", flags[1], nf);
            cmp(rc, "carry", flags[0], cy);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=done", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        op = 3'd0; a = 8'h00; b = 8'h00; cin = 1'b0;
        #1.1;
        rst_n = 1'b1;
        // Idle inputs: zero result, zero flag set (R5)
        #0.25;
        check_vec;
        #0.25;
        for (int o = 0; o < 8; o++) begin
            for (int c = 0; c < 2; c++) begin
                for (int x = 0; x < 256; x++) begin
                    for (int y = 0; y < 256; y++) begin
                        op = 3'(o); cin = 1'(c); a = 8'(x); b = 8'(y);
                        #0.25;
                        check_vec;
                        #0.25;
                    end
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule